// File: doc/BRIEF.md
# Component Handler Output Sequencer

This block drives the four-line digital port between a test instrument and an automated part handler. Lines 1 to 3 (`lines_o[2:0]`) carry a three-bit bin code, so up to eight bins can be addressed. When a test completes, the block places the pass or the fail pattern on those lines. It keeps that code there until the next result arrives.

Line 4 (`lines_o[3]`) has two uses. In end-of-test mode it is a latch strobe for handlers that hold the bin code in a register. The strobe is raised only after the code has been stable for a programmed number of cycles. It then stays active for a programmed width, and its resting level follows a polarity setting. In the two busy modes, used with pulse-type handlers, line 4 is a busy flag: in the plain form it is high during a test, and in the inverted form it is low during a test. The flag is set by the start-of-test strobe and cleared by the test-complete strobe.

A result that arrives while a strobe sequence is running is held in a one-entry slot. It is sent as soon as the current pulse ends, so no result is lost and no strobe is cut short.

Top module: `handler_bin_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows bin code 000 and a cleared busy flag, no strobe sequence is running, and line 4 sits at the idle level of the selected mode.
- R2: A cycle with `done_i` high loads the bin code at the next edge, in every mode. The code is `pass_pat_i[2:0]` when `pass_i` is 1 and `fail_pat_i[2:0]` when `pass_i` is 0. Bit 3 of either pattern never reaches the outputs.
- R3: Lines 1 to 3 keep their code, whatever the pattern inputs do, until a new result is loaded.
- R4: In end-of-test mode (`mode_i` = 00), line 4 becomes active exactly `setup_cyc_i` cycles after the code changes. It stays active for exactly `width_cyc_i` cycles and then returns to idle. A programmed value of 0 counts as 1.
- R5: With `strobe_low_i` = 1, the strobe idles high and pulses low. With `strobe_low_i` = 0, it idles low and pulses high.
- R6: A `done_i` that arrives during a running sequence is queued. At the edge where the pulse ends, the queued code is loaded and a new setup-and-pulse sequence starts. If several results arrive during one sequence, only the newest is kept.
- R7: In busy mode (`mode_i` = 01), line 4 goes high at the edge after `sot_i` and goes low at the edge after `done_i`. If both strobes arrive in the same cycle, `done_i` wins.
- R8: In inverted-busy mode (`mode_i` = 10 or 11), line 4 is the complement of the busy flag: high when idle and low during a test.
- R9: With no sequence running, a change of `mode_i` or `strobe_low_i` moves line 4 to the new idle level in the same cycle, with no clock edge needed.
- R10: In the busy modes, line 4 never pulses. It changes only in response to `sot_i` or `done_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sot_i | input | 1 | Start-of-test strobe, one cycle |
| done_i | input | 1 | Test-complete strobe, one cycle |
| pass_i | input | 1 | Result that goes with `done_i`: 1 = pass |
| pass_pat_i | input | CODE_W+1 | Pass pattern; bits [2:0] are the bin code |
| fail_pat_i | input | CODE_W+1 | Fail pattern; bits [2:0] are the bin code |
| mode_i | input | 2 | 00 end-of-test, 01 busy, 1x inverted busy |
| strobe_low_i | input | 1 | 1 = low-going strobe, 0 = high-going strobe |
| setup_cyc_i | input | CW | Cycles between the code change and the strobe edge |
| width_cyc_i | input | CW | Strobe width in cycles |
| lines_o | output | CODE_W+1 | [2:0] bin code on lines 1 to 3; [3] is line 4 |

## Verification
The bench models a handler register that captures lines 1 to 3 on each active strobe edge. It measures how many cycles the code was stable before that edge and how long the strobe lasted. A design that raised the strobe together with the code change would latch the previous bin. A design that ignored a zero setting would give a setup or width of zero instead of one.

Results are injected during both the setup phase and the pulse phase. A design without the queue would lose the second bin. A design that kept the oldest queued result, instead of the newest, would latch the wrong code.

Polarity and mode are flipped while idle and line 4 is read in the same cycle, which exposes a line 4 that lags by one register. The busy and inverted-busy runs expose a swapped idle level. Patterns with bit 3 set expose a code built from the wrong bits.

// File: rtl/hseq_pkg.sv
// Shared types for the handler output sequencer.
// Assumes: the mode encoding below is fixed by the block's port contract.
package hseq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SETUP = 2'd1,
        SQ_PULSE = 2'd2
    } sq_state_e;

    localparam logic [1:0] MODE_EOT  = 2'b00;
    localparam logic [1:0] MODE_BUSY = 2'b01;

    // True when line 4 acts as an end-of-test latch strobe.
    function automatic logic is_eot(input logic [1:0] m);
        return m == MODE_EOT;
    endfunction

endpackage

// File: rtl/hseq_timer.sv
// Down-counter that times the setup and pulse phases.
// Loads a cycle count, with 0 forced up to 1, and reports the last cycle.
// Assumes: the user loads it only when a phase starts.
module hseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Load on a phase start, then count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (load_val == '0) ? CW'(1) : load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/hseq_sequencer.sv
// Sequence controller for the end-of-test strobe.
// On a result it asks for a code load and, in end-of-test mode, runs a
// setup phase and then a pulse phase. A result that arrives during a
// sequence is held in a one-entry slot; the newest result wins.
// Assumes: mode and cycle settings stay constant while a sequence runs.
module hseq_sequencer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eot_en,
    input  logic          done_i,
    input  logic          pass_i,
    input  logic [CW-1:0] setup_cyc,
    input  logic [CW-1:0] width_cyc,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          take,
    output logic          take_pass,
    output logic          strobe_on
);
    import hseq_pkg::*;

    sq_state_e st_q, st_d;
    logic      pend_q, pend_d;
    logic      pend_pass_q, pend_pass_d;

    // Work out the next state, timer loads and code-load requests.
    always_comb begin
        st_d        = st_q;
        pend_d      = pend_q;
        pend_pass_d = pend_pass_q;
        tmr_load    = 1'b0;
        tmr_val     = setup_cyc;
        take        = 1'b0;
        take_pass   = done_i ? pass_i : pend_pass_q;
        case (st_q)
            SQ_IDLE: begin
                if (done_i) begin
                    take = 1'b1;
                    if (eot_en) begin
                        st_d     = SQ_SETUP;
                        tmr_load = 1'b1;
                    end
                end
            end
            SQ_SETUP: begin
                if (done_i) begin
                    pend_d      = 1'b1;
                    pend_pass_d = pass_i;
                end
                if (tmr_last) begin
                    st_d     = SQ_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = width_cyc;
                end
            end
            SQ_PULSE: begin
                if (tmr_last) begin
                    if (done_i || pend_q) begin
                        take     = 1'b1;
                        pend_d   = 1'b0;
                        st_d     = SQ_SETUP;
                        tmr_load = 1'b1;
                    end else begin
                        st_d = SQ_IDLE;
                    end
                end else if (done_i) begin
                    pend_d      = 1'b1;
                    pend_pass_d = pass_i;
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    // Register the state and the queued result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SQ_IDLE;
            pend_q      <= 1'b0;
            pend_pass_q <= 1'b0;
        end else begin
            st_q        <= st_d;
            pend_q      <= pend_d;
            pend_pass_q <= pend_pass_d;
        end
    end

    assign strobe_on = (st_q == SQ_PULSE);
endmodule

// File: rtl/hseq_line4.sv
// Line 4 driver: holds the busy flag and picks the line 4 level.
// In end-of-test mode line 4 is the strobe at the chosen polarity; in
// the busy modes it is the busy flag or its complement.
// Assumes: mode and polarity are read combinationally, so an idle
// change shows on the line in the same cycle.
module hseq_line4 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sot_i,
    input  logic       done_i,
    input  logic [1:0] mode_i,
    input  logic       strobe_low,
    input  logic       strobe_on,
    output logic       line4
);
    import hseq_pkg::*;

    logic busy_q;

    // Busy flag: set by start of test, cleared by test complete (wins).
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (done_i)
            busy_q <= 1'b0;
        else if (sot_i)
            busy_q <= 1'b1;
    end

    // Choose the line 4 level for the selected mode.
    always_comb begin
        if (is_eot(mode_i))
            line4 = strobe_low ^ strobe_on;
        else if (mode_i == MODE_BUSY)
            line4 = busy_q;
        else
            line4 = ~busy_q;
    end
endmodule

// File: rtl/handler_bin_seq.sv
// Top of the handler output sequencer: bin code register, strobe
// sequencer with its timer, and the line 4 driver.
// Assumes: one-cycle sot_i/done_i strobes; configuration stays constant
// while an end-of-test sequence runs.
module handler_bin_seq #(
    parameter int CODE_W = 3,
    parameter int CW     = 8,
    localparam int PAT_W = CODE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sot_i,
    input  logic             done_i,
    input  logic             pass_i,
    input  logic [PAT_W-1:0] pass_pat_i,
    input  logic [PAT_W-1:0] fail_pat_i,
    input  logic [1:0]       mode_i,
    input  logic             strobe_low_i,
    input  logic [CW-1:0]    setup_cyc_i,
    input  logic [CW-1:0]    width_cyc_i,
    output logic [PAT_W-1:0] lines_o
);
    import hseq_pkg::*;

    logic              tmr_load, tmr_last;
    logic [CW-1:0]     tmr_val;
    logic              take, take_pass, strobe_on, line4;
    logic [CODE_W-1:0] code_q;

    hseq_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    hseq_sequencer #(.CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .eot_en    (is_eot(mode_i)),
        .done_i    (done_i),
        .pass_i    (pass_i),
        .setup_cyc (setup_cyc_i),
        .width_cyc (width_cyc_i),
        .tmr_last  (tmr_last),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .take      (take),
        .take_pass (take_pass),
        .strobe_on (strobe_on)
    );

    hseq_line4 u_l4 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sot_i      (sot_i),
        .done_i     (done_i),
        .mode_i     (mode_i),
        .strobe_low (strobe_low_i),
        .strobe_on  (strobe_on),
        .line4      (line4)
    );

    // Bin code register: loads the pass or fail code on a take request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (take)
            code_q <= take_pass ? pass_pat_i[CODE_W-1:0] : fail_pat_i[CODE_W-1:0];
    end

    assign lines_o = {line4, code_q};
endmodule

// File: rtl/hseq_chk.sv
// Property checker for handler_bin_seq, attached with bind.
// Assumes: configuration stays constant during end-of-test sequences.
module hseq_chk #(
    parameter int CODE_W = 3,
    parameter int CW     = 8,
    localparam int PAT_W = CODE_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sot_i,
    input logic             done_i,
    input logic             pass_i,
    input logic [PAT_W-1:0] pass_pat_i,
    input logic [PAT_W-1:0] fail_pat_i,
    input logic [1:0]       mode_i,
    input logic             strobe_low_i,
    input logic [CW-1:0]    setup_cyc_i,
    input logic [CW-1:0]    width_cyc_i,
    input logic [PAT_W-1:0] lines_o
);
    logic act;
    assign act = (mode_i == 2'b00) && (lines_o[PAT_W-1] != strobe_low_i);

    // R2
    code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b00 && done_i) |=> lines_o[CODE_W-1:0] ==
            ($past(pass_i) ? $past(pass_pat_i[CODE_W-1:0]) : $past(fail_pat_i[CODE_W-1:0])));

    // R4
    strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> $stable(lines_o[CODE_W-1:0]));

    // R7
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && $past(mode_i) == 2'b01 && $past(sot_i) && !$past(done_i))
            |-> lines_o[PAT_W-1]);

    // R8
    nbusy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && $past(mode_i[1]) && $past(done_i)) |-> lines_o[PAT_W-1]);

    // R10
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 && $past(mode_i) == 2'b01 && !$past(sot_i) && !$past(done_i))
            |-> $stable(lines_o[PAT_W-1]));
endmodule

bind handler_bin_seq hseq_chk #(.CODE_W(CODE_W), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sot_i        (sot_i),
    .done_i       (done_i),
    .pass_i       (pass_i),
    .pass_pat_i   (pass_pat_i),
    .fail_pat_i   (fail_pat_i),
    .mode_i       (mode_i),
    .strobe_low_i (strobe_low_i),
    .setup_cyc_i  (setup_cyc_i),
    .width_cyc_i  (width_cyc_i),
    .lines_o      (lines_o)
);

// File: tb/sim_handler_bin_seq.sv
// Scoreboard bench: the driver queues the expected latches (code, setup,
// width) and a handler-register model pops and compares them.
module sim_handler_bin_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sot = 1'b0, done = 1'b0, pass = 1'b0;
    logic [3:0] pass_pat = '0, fail_pat = '0;
    logic [1:0] mode = 2'b00;
    logic       slow = 1'b1;
    logic [7:0] setup_c = 8'd1, width_c = 8'd1;
    logic [3:0] lines;
    int checks = 0, errors = 0;
    bit fin = 0;

    typedef struct packed { logic [2:0] code; logic [7:0] su; logic [7:0] wd; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    handler_bin_seq u0 (
        .clk(clk), .rst_n(rst_n), .sot_i(sot), .done_i(done), .pass_i(pass),
        .pass_pat_i(pass_pat), .fail_pat_i(fail_pat), .mode_i(mode),
        .strobe_low_i(slow), .setup_cyc_i(setup_c), .width_cyc_i(width_c),
        .lines_o(lines)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [2:0] c, input logic [7:0] s, input logic [7:0] w);
        exp_t e;
        e.code = c;
        e.su = (s == 0) ? 8'd1 : s;
        e.wd = (w == 0) ? 8'd1 : w;
        q.push_back(e);
    endtask

    task automatic give(input logic p);
        pass = p; done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    // Handler register model: latches lines 1-3 on the active strobe edge.
    logic [2:0] prev_code = '0;
    logic       prev_act = 1'b0;
    int         idle_n = 0, act_n = 0;
    logic [7:0] exp_wd = '0;
    always @(negedge clk) begin
        logic a;
        exp_t e;
        a = (mode == 2'b00) && (lines[3] != slow);
        if (rst_n && mode == 2'b00) begin
            if (a && !prev_act) begin
                if (q.size() == 0) begin
                    chk("R6 unexpected strobe", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk("R4/R6 latched code", int'(lines[2:0]), int'(e.code));
                    chk("R4 setup cycles", idle_n, int'(e.su));
                    exp_wd = e.wd;
                end
                act_n = 1;
            end else if (a) begin
                act_n++;
            end
            if (!a && prev_act) chk("R4/R5 strobe width", act_n, int'(exp_wd));
            if (lines[2:0] != prev_code || (prev_act && !a)) idle_n = 1;
            else if (!a) idle_n++;
        end
        prev_code = lines[2:0];
        prev_act  = a;
    end

    initial begin
        repeat (3) tick();
        chk("R1 reset lines", int'(lines), 8);
        rst_n = 1'b1;
        tick();
        // R2 R4 R5: low-going strobe, pass code
        setup_c = 8'd3; width_c = 8'd2;
        pass_pat = 4'b0101; fail_pat = 4'b1010;
        chk("R5 idle high", int'(lines[3]), 1);
        push(3'b101, 3, 2); give(1'b1);
        chk("R2 pass code", int'(lines[2:0]), 5);
        repeat (10) tick();
        // R2: bit 3 of the pattern is ignored
        push(3'b010, 3, 2); give(1'b0);
        chk("R2 fail code bit3 ignored", int'(lines[2:0]), 2);
        repeat (10) tick();
        // R9 R5: polarity change while idle, then high-going strobe
        slow = 1'b0; #1;
        chk("R9 polarity idle level", int'(lines[3]), 0);
        setup_c = 8'd1; width_c = 8'd1; pass_pat = 4'b1110;
        push(3'b110, 1, 1); give(1'b1);
        repeat (6) tick();
        // R4: zero settings act as one
        setup_c = 8'd0; width_c = 8'd0; fail_pat = 4'b0001;
        push(3'b001, 0, 0); give(1'b0);
        repeat (6) tick();
        // R6 R3: result arriving during the pulse
        slow = 1'b1; setup_c = 8'd2; width_c = 8'd4;
        pass_pat = 4'b0011; fail_pat = 4'b0100;
        push(3'b011, 2, 4); push(3'b100, 2, 4);
        give(1'b1); tick(); tick();
        give(1'b0);
        chk("R3 code held during pulse", int'(lines[2:0]), 3);
        repeat (20) tick();
        // R6: newest of two queued results wins
        push(3'b011, 2, 4); push(3'b011, 2, 4);
        give(1'b1); give(1'b0); tick(); give(1'b1);
        repeat (20) tick();
        chk("R6 final code newest", int'(lines[2:0]), 3);
        chk("R6 all latches seen", q.size(), 0);
        // R7 R10 R9: busy mode
        mode = 2'b01; #1;
        chk("R9 busy idle level", int'(lines[3]), 0);
        pass_pat = 4'b0110;
        sot = 1'b1; tick(); sot = 1'b0;
        chk("R7 busy after sot", int'(lines[3]), 1);
        repeat (3) tick();
        chk("R10 busy held", int'(lines[3]), 1);
        give(1'b1);
        chk("R7 busy cleared", int'(lines[3]), 0);
        chk("R2 code in busy mode", int'(lines[2:0]), 6);
        pass_pat = 4'b0001;
        repeat (3) tick();
        chk("R3 code held", int'(lines[2:0]), 6);
        sot = 1'b1; done = 1'b1; tick(); sot = 1'b0; done = 1'b0;
        chk("R7 done wins over sot", int'(lines[3]), 0);
        // R8: inverted busy
        mode = 2'b10; #1;
        chk("R9 inverted idle level", int'(lines[3]), 1);
        sot = 1'b1; tick(); sot = 1'b0;
        chk("R8 low during test", int'(lines[3]), 0);
        give(1'b0);
        chk("R8 high after test", int'(lines[3]), 1);
        chk("R2 fail code inverted mode", int'(lines[2:0]), 4);
        mode = 2'b11; #1;
        sot = 1'b1; tick(); sot = 1'b0;
        chk("R8 mode 11 low during test", int'(lines[3]), 0);
        give(1'b1);
        chk("R10 no pulse in busy modes", q.size(), 0);
        fin = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!fin) begin
            checks++; errors++;
            $display("FAIL R1 watchdog got=hang exp=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule